// File: doc/BRIEF.md
# Single-Level Prioritised Interrupt Controller

This block collects requests from five interrupt sources: external request A, timer 0, external request B, a dedicated interval timer and a two-wire serial bus unit. It masks them through one 8-bit enable register, and it presents a single request to a processor core. When the core acknowledges, the block picks the pending, enabled source with the highest fixed priority. It latches the entry address of that source's service routine, then holds the grant until the core signals the return from the routine.

There is one priority level and no nesting. While a routine is running, no further request is raised, whatever arrives at the source inputs. After reset the vector output shows the reset entry address. The enable register has a global-enable bit in bit 7. Bits 6 and 5 are unused. Bits 4..0 each gate one source.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, `vecAddr` is 0x000 (the reset entry), `cpuReq` is 0, `inService` is 0 and `activeSrc` is 0.
- R2: A write stores `enWdata` with bits 6 and 5 forced to 0, so a write of 0xFF reads back 0x9F from the next cycle on.
- R3: While enable bit 7 (global enable) is 0, `cpuReq` stays 0 whatever bits 4..0 and `srcPending` hold.
- R4: With bit 7 set, a source takes part only if its own enable bit is 1. The source-to-bit map is: bit 0 = external A, bit 1 = timer 0, bit 2 = external B, bit 3 = dedicated timer, bit 4 = serial bus. The same map applies to `srcPending` and `activeSrc`.
- R5: Among eligible sources, the lowest-numbered bit wins. Bit 0 has the highest priority and bit 4 the lowest.
- R6: On a cycle with `cpuReq` and `cpuAck` both 1, the next cycle shows `inService` = 1, `activeSrc` one-hot on the winner and `vecAddr` = 0x003 + 8 × index. This gives 0x003, 0x00B, 0x013, 0x01B or 0x023.
- R7: While `inService` is 1, `cpuReq` stays 0. A `cpuReti` pulse clears `inService` and `activeSrc` in the next cycle, after which requests are raised again.
- R8: The latched `vecAddr` and `activeSrc` do not change during service when `srcPending` changes. An `cpuAck` given while `cpuReq` is 0 and a `cpuReti` given while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enWrite | input | 1 | Write strobe for the enable register |
| enWdata | input | 8 | Value to write into the enable register |
| enRdata | output | 8 | Current enable register contents |
| srcPending | input | 5 | Pending flags of the five sources |
| cpuReq | output | 1 | Interrupt request to the core |
| cpuAck | input | 1 | Core accepts the request |
| cpuReti | input | 1 | Core returned from the service routine |
| vecAddr | output | 12 | Entry address of the granted routine, or the reset entry |
| activeSrc | output | 5 | One-hot source in service |
| inService | output | 1 | A routine is in service |

## Verification
The bench sets every pending pattern in which a higher source masks a lower one. A priority encoder with the wrong order or a wrong tie-break would grant the wrong source and send the core to the wrong entry address. It raises all sources with the global bit cleared. A design that gated with the per-source bits only would request anyway. During service it changes the pending inputs. A design that decoded the vector combinationally would move `vecAddr`, and one that allowed nesting would request again. It also sends stray acknowledge and return pulses. A design that did not qualify them would enter service with no request, or would drop a grant.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int NUM_SRC    = 5;
  localparam int ENABLE_W   = 8;
  localparam int GLOBAL_BIT = 7;
  localparam int VEC_W      = 12;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;

  typedef enum logic {ST_IDLE, ST_SERVICE} ctrlState_t;

  typedef struct packed {
    logic latchVec;
    logic clearSrc;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
#(
  parameter int N_SRC  = NUM_SRC,
  parameter int EN_W   = ENABLE_W,
  parameter int G_BIT  = GLOBAL_BIT,
  parameter int V_W    = VEC_W,
  parameter int V_BASE = VEC_BASE,
  parameter int V_STEP = VEC_STRIDE
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enWrite,
  input  logic [EN_W-1:0]  enWdata,
  input  logic [N_SRC-1:0] srcPending,
  input  ctrlStrobe_t      strobe,
  output logic [EN_W-1:0]  enReg,
  output logic             anyEligible,
  output logic [V_W-1:0]   vecAddr,
  output logic [N_SRC-1:0] activeSrc
);
  localparam logic [EN_W-1:0] KEEP_MASK =
    EN_W'((1 << N_SRC) - 1) | (EN_W'(1) << G_BIT);

  logic [N_SRC-1:0] eligible;
  logic [N_SRC-1:0] winner;
  logic [N_SRC-1:0] higherSeen;
  int               winIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enReg <= '0;
    else if (enWrite) enReg <= enWdata & KEEP_MASK;
  end

  assign eligible    = srcPending & enReg[N_SRC-1:0] & {N_SRC{enReg[G_BIT]}};
  assign anyEligible = |eligible;

  assign higherSeen[0] = 1'b0;
  assign winner[0]     = eligible[0];
  for (genvar i = 1; i < N_SRC; i++) begin : g_prio
    assign higherSeen[i] = higherSeen[i-1] | eligible[i-1];
    assign winner[i]     = eligible[i] & ~higherSeen[i];
  end

  always_comb begin
    winIdx = 0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (winner[k]) winIdx = k;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecAddr   <= '0;
      activeSrc <= '0;
    end else if (strobe.latchVec) begin
      vecAddr   <= V_W'(V_BASE + V_STEP * winIdx);
      activeSrc <= winner;
    end else if (strobe.clearSrc) begin
      activeSrc <= '0;
    end
  end
endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyEligible,
  input  logic        cpuAck,
  input  logic        cpuReti,
  output logic        cpuReq,
  output logic        inService,
  output ctrlStrobe_t strobe
);
  ctrlState_t state;

  assign cpuReq          = (state == ST_IDLE) && anyEligible;
  assign inService       = (state == ST_SERVICE);
  assign strobe.latchVec = cpuReq && cpuAck;
  assign strobe.clearSrc = inService && cpuReti;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else if (strobe.latchVec) state <= ST_SERVICE;
    else if (strobe.clearSrc) state <= ST_IDLE;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                enWrite,
  input  logic [ENABLE_W-1:0] enWdata,
  output logic [ENABLE_W-1:0] enRdata,
  input  logic [NUM_SRC-1:0]  srcPending,
  output logic                cpuReq,
  input  logic                cpuAck,
  input  logic                cpuReti,
  output logic [VEC_W-1:0]    vecAddr,
  output logic [NUM_SRC-1:0]  activeSrc,
  output logic                inService
);
  ctrlStrobe_t strobe;
  logic        anyEligible;

  irqDatapath u_dp (
    .clk(clk), .rstN(rstN), .enWrite(enWrite), .enWdata(enWdata),
    .srcPending(srcPending), .strobe(strobe), .enReg(enRdata),
    .anyEligible(anyEligible), .vecAddr(vecAddr), .activeSrc(activeSrc)
  );

  irqControl u_ctl (
    .clk(clk), .rstN(rstN), .anyEligible(anyEligible), .cpuAck(cpuAck),
    .cpuReti(cpuReti), .cpuReq(cpuReq), .inService(inService), .strobe(strobe)
  );
endmodule

// File: rtl/irqPrioCheck.sv
module irqPrioCheck
  import irqPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                enWrite,
  input logic [ENABLE_W-1:0] enWdata,
  input logic [ENABLE_W-1:0] enRdata,
  input logic [NUM_SRC-1:0]  srcPending,
  input logic                cpuReq,
  input logic                cpuAck,
  input logic                cpuReti,
  input logic [VEC_W-1:0]    vecAddr,
  input logic [NUM_SRC-1:0]  activeSrc,
  input logic                inService
);
  logic [NUM_SRC-1:0] gated;
  logic [NUM_SRC-1:0] lowest;
  assign gated  = srcPending & enRdata[NUM_SRC-1:0];
  assign lowest = gated & (~gated + NUM_SRC'(1));

  assert_write_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    enWrite |=> enRdata == ($past(enWdata) & 8'h9F));

  assert_global_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    !enRdata[GLOBAL_BIT] |-> !cpuReq);

  assert_gated_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> (gated != '0));

  assert_priority_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuAck) |=> activeSrc == $past(lowest));

  assert_grant_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuAck) |=> (inService && $onehot(activeSrc)));

  assert_no_nest_R7: assert property (@(posedge clk) disable iff (!rstN)
    inService |-> !cpuReq);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inService && !cpuReti) |=> ($stable(activeSrc) && $stable(vecAddr) && inService));
endmodule

bind irq_prio_ctrl irqPrioCheck chk (.*);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enWrite = 1'b0;
  logic [7:0]  enWdata = '0;
  logic [7:0]  enRdata;
  logic [4:0]  srcPending = '0;
  logic        cpuReq;
  logic        cpuAck = 1'b0;
  logic        cpuReti = 1'b0;
  logic [11:0] vecAddr;
  logic [4:0]  activeSrc;
  logic        inService;

  int errors = 0;
  int checks = 0;
  bit prevSvc = 1'b0;

  typedef struct {logic [11:0] vec; logic [4:0] src;} expItem_t;
  expItem_t expQ[$];

  irq_prio_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic writeEn(logic [7:0] v);
    enWrite = 1'b1; enWdata = v;
    tick();
    enWrite = 1'b0;
  endtask

  // driver: push expected grant, acknowledge, disturb, return
  task automatic takeIrq(logic [4:0] pend, int idx);
    expItem_t it;
    srcPending = pend;
    #1;
    check("R4 request raised", 32'(cpuReq), 32'd1);
    it.vec = 12'(3 + 8 * idx);
    it.src = 5'(1 << idx);
    expQ.push_back(it);
    cpuAck = 1'b1;
    tick();
    cpuAck = 1'b0;
    srcPending = 5'h1F;
    tick();
    check("R7 no request in service", 32'(cpuReq), 32'd0);
    check("R8 source held", 32'(activeSrc), 32'(it.src));
    check("R8 vector held", 32'(vecAddr), 32'(it.vec));
    cpuReti = 1'b1;
    tick();
    cpuReti = 1'b0;
    check("R7 return clears service", 32'(inService), 32'd0);
    check("R7 return clears source", 32'(activeSrc), 32'd0);
    srcPending = '0;
    tick();
  endtask

  // monitor: compare each new grant against the queue
  always @(negedge clk) begin
    if (rstN && inService && !prevSvc) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected grant actual=%0h expected=none", vecAddr);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (vecAddr !== e.vec || activeSrc !== e.src) begin
          errors++;
          $display("FAIL R5/R6 grant actual=%0h/%0h expected=%0h/%0h",
                   vecAddr, activeSrc, e.vec, e.src);
        end
      end
    end
    prevSvc = inService;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    check("R1 enable reset", 32'(enRdata), 32'h00);
    check("R1 reset vector", 32'(vecAddr), 32'h000);
    check("R1 no request", 32'(cpuReq), 32'd0);
    check("R1 not in service", 32'(inService), 32'd0);
    check("R1 no source", 32'(activeSrc), 32'd0);

    writeEn(8'hFF);
    check("R2 reserved bits read 0", 32'(enRdata), 32'h9F);

    writeEn(8'h1F);
    srcPending = 5'h1F;
    #1;
    check("R3 global off blocks request", 32'(cpuReq), 32'd0);
    cpuAck = 1'b1;
    tick();
    cpuAck = 1'b0;
    check("R8 stray ack ignored", 32'(inService), 32'd0);
    check("R8 stray ack keeps vector", 32'(vecAddr), 32'h000);
    srcPending = '0;

    writeEn(8'h9F);
    for (int i = 0; i < 5; i++) takeIrq(5'(1 << i), i);   // R6 each entry address

    takeIrq(5'h1F, 0);   // R5
    takeIrq(5'h1E, 1);
    takeIrq(5'h1C, 2);
    takeIrq(5'h18, 3);

    writeEn(8'h94);
    takeIrq(5'h1F, 2);   // R4 masked higher sources skipped
    srcPending = 5'h0B;
    #1;
    check("R4 disabled sources ignored", 32'(cpuReq), 32'd0);
    srcPending = '0;

    cpuReti = 1'b1;
    tick();
    cpuReti = 1'b0;
    check("R8 idle return ignored", 32'(inService), 32'd0);
    check("R8 idle return keeps vector", 32'(vecAddr), 32'h013);

    tick();
    check("R6 queue drained", 32'(expQ.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule